// File: doc/BRIEF.md
# Parallel 8080-Style Frame Write Port

This block pushes one frame of pixel words into a command-mode panel that keeps its own frame memory. It drives a chip select, a write strobe and a parallel data bus. Each word is shaped by four timing fields in a configuration word: chip-select lead time, write setup, strobe-low width and hold. All four are counted in clock cycles.

Software starts a frame by writing the trigger word. From then on the block takes pixel words from a valid/ready source until the programmed word count has gone out. It then sets a sticky frame-done flag and leaves the busy state on that same clock edge. A trigger that arrives while a frame is still going out is dropped, because a repeated trigger can reset the panel.

Top module: `pwi_i80_writer`

## Requirements
- R1: After a synchronous active-low reset, `bus_cs_n` and `bus_wr_n` are high, and `busy`, `frame_done` and `pix_ready` are low.
- R2: A frame starts only on a cycle with `trig_we` high, both `trig_val[0]` (the I80 mode select) and `trig_val[1]` (the software start command) set, `cfg_word[0]` (interface enable) set and `frame_len` nonzero. A write that fails any of these conditions leaves `busy` low.
- R3: Each word holds `bus_cs_n` low for a contiguous run of phases, in this order: chip-select lead (`cfg_word[19:16]` cycles), write setup (`cfg_word[15:12]`), strobe low (`cfg_word[11:8]`) and hold (`cfg_word[7:4]`). After the run, `bus_cs_n` returns high.
- R4: A phase whose field is zero takes no cycles. The exception is the strobe-low phase: a zero there still gives exactly one cycle, so `bus_wr_n` is low for max(field,1) cycles. `bus_wr_n` is never low while `bus_cs_n` is high.
- R5: While `bus_cs_n` is low, `bus_data` holds the word accepted for that access and does not change.
- R6: `pix_ready` is high only while `busy` is high and no access is running, so it is always low while `bus_cs_n` is low. A word is taken on a cycle where both `pix_valid` and `pix_ready` are high.
- R7: After exactly `frame_len` words, `frame_done` is set and `busy` falls, both on the clock edge that ends the last access.
- R8: A trigger written while `busy` is high is ignored. The running frame still sends exactly its original word count.
- R9: `frame_done` stays set until a cycle with `done_clr` high clears it.
- R10: The timing fields and the word count are captured when a frame starts. Changing `cfg_word` or `frame_len` during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 32 | Timing fields [19:16],[15:12],[11:8],[7:4] and enable bit [0] |
| trig_we | input | 1 | Trigger word write strobe |
| trig_val | input | 2 | Bit 0 selects I80 mode, bit 1 is the start command |
| frame_len | input | LEN_W | Number of words in a frame |
| done_clr | input | 1 | Write-one-to-clear for the frame-done flag |
| pix_valid | input | 1 | Source has a pixel word |
| pix_data | input | DATA_W | Pixel word |
| pix_ready | output | 1 | Block takes the offered word |
| bus_cs_n | output | 1 | Panel chip select, active low |
| bus_wr_n | output | 1 | Panel write strobe, active low |
| bus_data | output | DATA_W | Panel data bus |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | Sticky frame-done flag |

## Verification
The bench builds the block with DATA_W=16 and LEN_W=8. With these values, short frames of one to four words reach the end-of-frame edge many times within a brief run. The four timing fields take their full range, from all-zero (where only the forced single strobe cycle remains) up to fifteen cycles each. A pixel source with gaps and a second trigger written mid-frame, together with a changed configuration word, show that the phase sequence and the word count stay as captured at the start.

// File: rtl/pwi_pkg.sv
// Shared types and field positions for the parallel write port.
// Assumes a 32-bit configuration word with 4-bit timing fields.
package pwi_pkg;
    localparam int FIELD_W  = 4;
    localparam int CS_LSB   = 16;
    localparam int WS_LSB   = 12;
    localparam int ACT_LSB  = 8;
    localparam int HOLD_LSB = 4;
    localparam int EN_BIT   = 0;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CSU,
        PH_WSU,
        PH_ACT,
        PH_HLD
    } phase_t;

    typedef struct packed {
        logic [FIELD_W-1:0] cs;
        logic [FIELD_W-1:0] ws;
        logic [FIELD_W-1:0] act;
        logic [FIELD_W-1:0] hold;
    } timing_t;

    function automatic timing_t unpack_timing(input logic [31:0] w);
        timing_t t;
        t.cs   = w[CS_LSB   +: FIELD_W];
        t.ws   = w[WS_LSB   +: FIELD_W];
        t.act  = w[ACT_LSB  +: FIELD_W];
        t.hold = w[HOLD_LSB +: FIELD_W];
        return t;
    endfunction
endpackage

// File: rtl/pwi_strobe_seq.sv
// Per-word access sequencer: on start it captures one data word and
// steps through lead, setup, strobe-low and hold phases. Zero-length
// phases are skipped, but the strobe phase always lasts at least one
// cycle. Assumes timing inputs stay stable for the whole access.
module pwi_strobe_seq
    import pwi_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    input  timing_t           tm,
    output logic              cs_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] dout,
    output logic              idle,
    output logic              word_end
);
    phase_t             st;
    phase_t             first_ph;
    phase_t             nxt_ph;
    logic [FIELD_W-1:0] cnt;

    // Cycle count to load on entering a phase (count value is length-1).
    function automatic logic [FIELD_W-1:0] load_of(input phase_t p, input timing_t t);
        case (p)
            PH_CSU:  return t.cs - 1'b1;
            PH_WSU:  return t.ws - 1'b1;
            PH_ACT:  return (t.act == '0) ? '0 : t.act - 1'b1;
            PH_HLD:  return t.hold - 1'b1;
            default: return '0;
        endcase
    endfunction

    // First phase of an access and the phase following the current one.
    always_comb begin
        if (tm.cs != '0)      first_ph = PH_CSU;
        else if (tm.ws != '0) first_ph = PH_WSU;
        else                  first_ph = PH_ACT;
        case (st)
            PH_CSU:  nxt_ph = (tm.ws != '0) ? PH_WSU : PH_ACT;
            PH_WSU:  nxt_ph = PH_ACT;
            PH_ACT:  nxt_ph = (tm.hold != '0) ? PH_HLD : PH_IDLE;
            default: nxt_ph = PH_IDLE;
        endcase
    end

    // Phase register, phase counter and captured data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= PH_IDLE;
            cnt  <= '0;
            dout <= '0;
        end else if (st == PH_IDLE) begin
            if (start) begin
                dout <= din;
                st   <= first_ph;
                cnt  <= load_of(first_ph, tm);
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else begin
            st  <= nxt_ph;
            cnt <= load_of(nxt_ph, tm);
        end
    end

    // Bus strobes decoded from the phase register.
    always_comb begin
        idle     = (st == PH_IDLE);
        cs_n     = idle;
        wr_n     = (st != PH_ACT);
        word_end = !idle && (cnt == '0) && (nxt_ph == PH_IDLE);
    end
endmodule

// File: rtl/pwi_frame_ctl.sv
// Frame controller: qualifies the trigger, captures timing and word
// count at frame start, counts finished words and keeps the sticky
// done flag. Assumes word_end pulses once per finished access.
module pwi_frame_ctl
    import pwi_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cfg_word,
    input  logic             trig_we,
    input  logic [1:0]       trig_val,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             done_clr,
    input  logic             word_end,
    output logic             busy,
    output logic             frame_done,
    output timing_t          tm
);
    logic [LEN_W-1:0] left_q;
    logic             start_ok;
    logic             last_end;

    // Trigger qualification and last-word detection.
    always_comb begin
        start_ok = trig_we && trig_val[0] && trig_val[1] && cfg_word[EN_BIT]
                   && (frame_len != '0) && !busy;
        last_end = busy && word_end && (left_q == LEN_W'(1));
    end

    // Busy state, remaining word count and captured timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            left_q <= '0;
            tm     <= '0;
        end else if (start_ok) begin
            busy   <= 1'b1;
            left_q <= frame_len;
            tm     <= unpack_timing(cfg_word);
        end else if (busy && word_end) begin
            left_q <= left_q - 1'b1;
            if (last_end) busy <= 1'b0;
        end
    end

    // Sticky done flag; a set on the same edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        frame_done <= 1'b0;
        else if (last_end) frame_done <= 1'b1;
        else if (done_clr) frame_done <= 1'b0;
    end
endmodule

// File: rtl/pwi_i80_writer.sv
// Top level of the parallel write port: joins the frame controller and
// the per-word sequencer and exposes the pixel handshake.
// Assumes the pixel source holds pix_data while pix_valid is high.
module pwi_i80_writer
    import pwi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic              trig_we,
    input  logic [1:0]        trig_val,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              done_clr,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              pix_ready,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_data,
    output logic              busy,
    output logic              frame_done
);
    timing_t tm;
    logic    seq_idle;
    logic    word_end;
    logic    take;

    // Handshake: accept a word only between accesses of a live frame.
    always_comb begin
        pix_ready = busy && seq_idle;
        take      = pix_valid && pix_ready;
    end

    pwi_frame_ctl #(.LEN_W(LEN_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_word   (cfg_word),
        .trig_we    (trig_we),
        .trig_val   (trig_val),
        .frame_len  (frame_len),
        .done_clr   (done_clr),
        .word_end   (word_end),
        .busy       (busy),
        .frame_done (frame_done),
        .tm         (tm)
    );

    pwi_strobe_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (take),
        .din      (pix_data),
        .tm       (tm),
        .cs_n     (bus_cs_n),
        .wr_n     (bus_wr_n),
        .dout     (bus_data),
        .idle     (seq_idle),
        .word_end (word_end)
    );
endmodule

// File: rtl/pwi_i80_writer_chk.sv
// Checker for the parallel write port, bound to the top module.
module pwi_i80_writer_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_ready,
    input logic              bus_cs_n,
    input logic              bus_wr_n,
    input logic [DATA_W-1:0] bus_data,
    input logic              busy,
    input logic              frame_done
);
    AST_WR_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> !bus_cs_n);                                   // R4
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !$past(bus_cs_n)) |-> $stable(bus_data));    // R5
    AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> (busy && bus_cs_n));                          // R6
    AST_DONE_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> frame_done);                                // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done) |-> !busy);                               // R7
endmodule

bind pwi_i80_writer pwi_i80_writer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_ready  (pix_ready),
    .bus_cs_n   (bus_cs_n),
    .bus_wr_n   (bus_wr_n),
    .bus_data   (bus_data),
    .busy       (busy),
    .frame_done (frame_done)
);

// File: tb/sim_pwi_i80_writer.sv
// Bench: behavioural reference model compared on every clock.
module sim_pwi_i80_writer;
    localparam int DATA_W = 16;
    localparam int LEN_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       cfg_word = '0;
    logic              trig_we = 1'b0;
    logic [1:0]        trig_val = '0;
    logic [LEN_W-1:0]  frame_len = '0;
    logic              done_clr = 1'b0;
    logic              pix_valid = 1'b0;
    logic [DATA_W-1:0] pix_data = '0;
    logic              pix_ready, bus_cs_n, bus_wr_n, busy, frame_done;
    logic [DATA_W-1:0] bus_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit src_en  = 1'b0;
    bit gap     = 1'b0;
    bit live    = 1'b0;
    bit ended   = 1'b0;

    // reference model state
    int m_busy = 0, m_left = 0, m_pos = -1, m_total = 0, m_irq = 0;
    int m_cs = 0, m_ws = 0, m_a = 1, m_h = 0, src_cnt = 0;
    int m_data = 0;

    always #5 clk = ~clk;

    pwi_i80_writer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .trig_we(trig_we),
        .trig_val(trig_val), .frame_len(frame_len), .done_clr(done_clr),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_data(bus_data),
        .busy(busy), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_left = 0; m_pos = -1; m_irq = 0;
        end else begin
            if (done_clr) m_irq = 0;
            if (m_pos >= 0) begin
                if (m_pos == m_total - 1) begin
                    m_pos = -1;
                    m_left--;
                    if (m_left == 0) begin m_busy = 0; m_irq = 1; end
                end else m_pos++;
            end else if (m_busy != 0 && pix_valid) begin
                m_data = int'(pix_data);
                m_pos  = 0;
                src_cnt++;
            end else if (m_busy == 0 && trig_we && trig_val == 2'b11 && cfg_word[0]
                         && frame_len != 0) begin
                m_cs = int'(cfg_word[19:16]); m_ws = int'(cfg_word[15:12]);
                m_a  = (cfg_word[11:8] == 0) ? 1 : int'(cfg_word[11:8]);
                m_h  = int'(cfg_word[7:4]);
                m_total = m_cs + m_ws + m_a + m_h;
                m_left = int'(frame_len);
                m_busy = 1;
            end
        end
    end

    // Compare outputs away from the edge.
    always @(posedge clk) begin
        #2;
        if (live) begin
            bit e_cs_n, e_wr_n, e_rdy;
            e_cs_n = !(m_pos >= 0);
            e_wr_n = !(m_pos >= m_cs + m_ws && m_pos < m_cs + m_ws + m_a);
            e_rdy  = (m_busy != 0) && (m_pos < 0);
            chk(bus_cs_n == e_cs_n, "R3 bus_cs_n", bus_cs_n, e_cs_n);
            chk(bus_wr_n == e_wr_n, "R4 bus_wr_n", bus_wr_n, e_wr_n);
            chk(pix_ready == e_rdy, "R6 pix_ready", pix_ready, e_rdy);
            chk(busy == (m_busy != 0), "R7 busy", busy, m_busy);
            chk(frame_done == (m_irq != 0), "R9 frame_done", frame_done, m_irq);
            if (!e_cs_n) chk(int'(bus_data) == m_data, "R5 bus_data", bus_data, m_data);
        end
    end

    // Pixel source with optional gaps.
    always @(negedge clk) begin
        pix_data  <= DATA_W'(16'hA500 ^ (src_cnt * 37));
        pix_valid <= src_en && !(gap && (cycles % 3 == 0));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic trigger(input logic [31:0] cw, input int len, input logic [1:0] tv);
        @(negedge clk);
        cfg_word = cw; frame_len = LEN_W'(len); trig_val = tv; trig_we = 1'b1;
        @(negedge clk);
        trig_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && m_busy != 0; i++) @(negedge clk);
        cyc(2);
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    function automatic logic [31:0] mk(input int cs, ws, a, h, en);
        return (32'(cs) << 16) | (32'(ws) << 12) | (32'(a) << 8) | (32'(h) << 4) | 32'(en);
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        cyc(3);
        rst_n = 1'b1;
        live  = 1'b1;
        // R1: reset state
        chk(bus_cs_n && bus_wr_n && !busy && !frame_done && !pix_ready, "R1 reset", busy, 0);
        src_en = 1'b1;

        // R3 mixed timing, three words; R7 completion count
        base = src_cnt;
        trigger(mk(2, 1, 3, 2, 1), 3, 2'b11);
        wait_idle();
        chk(src_cnt - base == 3, "R7 words sent", src_cnt - base, 3);
        chk(frame_done == 1'b1, "R7 done set", frame_done, 1);

        // R9 sticky until cleared
        cyc(4);
        chk(frame_done == 1'b1, "R9 still set", frame_done, 1);
        clear_done();
        cyc(1);
        chk(frame_done == 1'b0, "R9 cleared", frame_done, 0);

        // R4 all-zero fields: single strobe cycle
        trigger(mk(0, 0, 0, 0, 1), 2, 2'b11);
        wait_idle();
        clear_done();

        // R2 qualification: missing mode bit, missing enable, zero length
        trigger(mk(1, 1, 1, 1, 1), 2, 2'b10);
        cyc(3);
        chk(busy == 1'b0, "R2 no mode bit", busy, 0);
        trigger(mk(1, 1, 1, 1, 0), 2, 2'b11);
        cyc(3);
        chk(busy == 1'b0, "R2 disabled", busy, 0);
        trigger(mk(1, 1, 1, 1, 1), 0, 2'b11);
        cyc(3);
        chk(busy == 1'b0, "R2 zero length", busy, 0);

        // R8 retrigger mid-frame; R10 cfg changed mid-frame; gaps in source
        gap  = 1'b1;
        base = src_cnt;
        trigger(mk(1, 0, 2, 0, 1), 4, 2'b11);
        cyc(5);
        trigger(mk(3, 3, 3, 3, 1), 9, 2'b11);
        wait_idle();
        chk(src_cnt - base == 4, "R8 retrigger ignored", src_cnt - base, 4);
        chk(frame_done == 1'b1, "R10 frame ended as captured", frame_done, 1);
        clear_done();
        gap = 1'b0;

        // R3 field extremes
        trigger(mk(15, 15, 15, 15, 1), 1, 2'b11);
        wait_idle();
        clear_done();
        trigger(mk(0, 2, 0, 4, 1), 2, 2'b11);
        wait_idle();
        chk(!busy && bus_cs_n && bus_wr_n, "R3 bus idle after frame", busy, 0);
        cyc(3);
        finish_run();
    end
endmodule